// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block drives the transmission gates of the egress queues of a set of switch ports. Each port has a small table of schedule slots. A slot holds an open/closed flag for each traffic class and a hold time in ticks. While the port is enabled, it plays its slots in order. After the last active slot it returns to slot 0 and keeps repeating. A free-running local tick, one per clock cycle, paces the playback. No external time reference is used. Enabling a port starts slot 0 on the next clock edge, and no start time is taken into account.

Each time a slot takes effect, the port raises a one-cycle event strobe. A shared monitor watches the strobes of all ports. Two ports must never switch gates on the same tick, so the monitor raises an error flag when this happens.

All pins are plain control and status signals. None carries a data stream, so there is no valid/ready handshake and no back-pressure. A slot or length write is accepted in the same cycle it is presented, provided the addressed port is disabled.

Top module: `tas_gate_scheduler`

## Requirements
- R1: `gate_open[p*NCLASS+n]` set to 1 opens traffic class n of port p. While a port is disabled, and after reset, all of its gate bits are 1 and its event strobe is 0.
- R2: On the first clock edge that samples `sched_en[p]` high, port p applies slot 0 and pulses `gate_evt[p]` for one cycle. No start time exists or is used.
- R3: A slot with hold time D keeps its mask for exactly D cycles. A hold time of 0 acts as 1.
- R4: After the last active slot, playback returns to slot 0, and a new `gate_evt` pulse marks each slot change. No pulse occurs inside a slot.
- R5: The active slot count per port is set by `cfg_len`. A count of 0 or 1 plays slot 0 alone. A count above NENTRY acts as NENTRY.
- R6: A slot write (`cfg_wr`) or count write (`cfg_len_wr`) addressed to an enabled port is ignored.
- R7: Taking `sched_en[p]` low returns the port to all-open on the next edge, and the next enable restarts at slot 0.
- R8: `clash_err` is 1 in the cycle after two or more ports pulsed `gate_evt` together, and 0 otherwise.
- R9: A two-slot cycle works as intended: mask 0x80 held for T1, then mask 0x7F held for T2, repeating every T1+T2 ticks. Hold times may be up to 2^DUR_W-1 ticks, which covers 100000/400000 at the default width of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | NPORT | Per-port run enable |
| cfg_wr | input | 1 | Write one slot |
| cfg_len_wr | input | 1 | Write the active slot count |
| cfg_port | input | PW | Target port of a write |
| cfg_slot | input | IW | Target slot index |
| cfg_gates | input | NCLASS | Slot gate mask |
| cfg_ticks | input | DUR_W | Slot hold time in ticks |
| cfg_len | input | IW+1 | Active slot count |
| gate_open | output | NPORT*NCLASS | Gate masks, port p at bits p*NCLASS upward |
| gate_evt | output | NPORT | One-cycle slot-change strobe per port |
| clash_err | output | 1 | Coincident gate events seen in the previous cycle |

## Verification
The bench builds the block with NPORT=2, NENTRY=4 and the default 8 classes and 20-bit hold times. With only four slots, every slot count from 0 to 5 can be swept together with several hold-time patterns, including zero-length slots. The expected mask and strobe for every cycle of several full cycles come from the offset since enable, taken modulo the summed hold times. Two ports make same-tick collisions and offset, collision-free runs easy to set up, and the two-slot 0x80/0x7F schedule is run at a scaled-down 100/400 ticks.

// File: rtl/tas_gate_pkg.sv
package tas_gate_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} seq_phase_e;
endpackage

// File: rtl/tas_slot_store.sv
module tas_slot_store #(
  parameter int NCLASS = 8,
  parameter int NENTRY = 16,
  parameter int DUR_W  = 20,
  localparam int IW    = (NENTRY > 1) ? $clog2(NENTRY) : 1,
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              wr,
  input  logic              len_wr,
  input  logic [IW-1:0]     wr_slot,
  input  logic [NCLASS-1:0] wr_gates,
  input  logic [DUR_W-1:0]  wr_ticks,
  input  logic [CW-1:0]     wr_len,
  input  logic [IW-1:0]     rd_slot,
  output logic [NCLASS-1:0] rd_gates,
  output logic [DUR_W-1:0]  rd_ticks,
  output logic [CW-1:0]     len_q
);
  logic [NCLASS-1:0] gates_mem [NENTRY];
  logic [DUR_W-1:0]  ticks_mem [NENTRY];

  always_ff @(posedge clk) begin
    if (wr && !locked) begin
      gates_mem[wr_slot] <= wr_gates;
      ticks_mem[wr_slot] <= wr_ticks;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 len_q <= CW'(1);
    else if (len_wr && !locked) len_q <= wr_len;
  end

  assign rd_gates = gates_mem[rd_slot];
  assign rd_ticks = ticks_mem[rd_slot];

  // R6: an enabled port keeps its slot count
  a_r6_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(len_q));
endmodule

// File: rtl/tas_port_seq.sv
module tas_port_seq
  import tas_gate_pkg::*;
#(
  parameter int NCLASS = 8,
  parameter int NENTRY = 16,
  parameter int DUR_W  = 20,
  localparam int IW    = (NENTRY > 1) ? $clog2(NENTRY) : 1,
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CW-1:0]     len,
  input  logic [NCLASS-1:0] rd_gates,
  input  logic [DUR_W-1:0]  rd_ticks,
  output logic [IW-1:0]     rd_slot,
  output logic [NCLASS-1:0] gates,
  output logic              evt
);
  seq_phase_e       phase;
  logic [IW-1:0]    slot;
  logic [DUR_W-1:0] left;
  logic [CW-1:0]    slot_inc;
  logic             take;
  logic [DUR_W-1:0] hold;

  always_comb begin
    slot_inc = {1'b0, slot} + CW'(1);
    if (phase == PH_IDLE || slot_inc >= len) rd_slot = '0;
    else                                     rd_slot = slot_inc[IW-1:0];
    take = (phase == PH_IDLE) || (left == '0);
    hold = (rd_ticks == '0) ? '0 : rd_ticks - DUR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase <= PH_IDLE;
      slot  <= '0;
      left  <= '0;
      gates <= '1;
      evt   <= 1'b0;
    end else if (take) begin
      phase <= PH_RUN;
      slot  <= rd_slot;
      left  <= hold;
      gates <= rd_gates;
      evt   <= 1'b1;
    end else begin
      left  <= left - DUR_W'(1);
      evt   <= 1'b0;
    end
  end

  // R1/R7: disabled means all open and quiet
  a_r7_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gates == '1) && !evt);
  // R2: the first enabled edge starts slot 0 with a strobe
  a_r2_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_IDLE) |=> evt && slot == '0);
  // R3: mask held while time remains
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_RUN && left != '0) |=> !evt && $stable(gates));
  // R5: pointer stays inside the table
  a_r5_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RUN |-> 32'(slot) < NENTRY);
endmodule

// File: rtl/tas_clash_monitor.sv
module tas_clash_monitor #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] evt,
  output logic             clash
);
  logic multi;
  always_comb begin
    multi = 1'b0;
    for (int i = 0; i < NPORT; i++)
      for (int j = i + 1; j < NPORT; j++)
        if (evt[i] && evt[j]) multi = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clash <= 1'b0;
    else        clash <= multi;
  end

  // R8: coincident strobes flag on the next cycle, lone ones do not
  a_r8_clash_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(evt) >= 2) |=> clash);
  a_r8_clash_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(evt) < 2) |=> !clash);
endmodule

// File: rtl/tas_gate_scheduler.sv
module tas_gate_scheduler #(
  parameter int NPORT  = 2,
  parameter int NCLASS = 8,
  parameter int NENTRY = 16,
  parameter int DUR_W  = 20,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int IW    = (NENTRY > 1) ? $clog2(NENTRY) : 1,
  localparam int CW    = IW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        sched_en,
  input  logic                    cfg_wr,
  input  logic                    cfg_len_wr,
  input  logic [PW-1:0]           cfg_port,
  input  logic [IW-1:0]           cfg_slot,
  input  logic [NCLASS-1:0]       cfg_gates,
  input  logic [DUR_W-1:0]        cfg_ticks,
  input  logic [CW-1:0]           cfg_len,
  output logic [NPORT*NCLASS-1:0] gate_open,
  output logic [NPORT-1:0]        gate_evt,
  output logic                    clash_err
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic              sel;
    logic [IW-1:0]     rd_slot;
    logic [NCLASS-1:0] rd_gates;
    logic [DUR_W-1:0]  rd_ticks;
    logic [CW-1:0]     len_q;

    assign sel = (32'(cfg_port) == p);

    tas_slot_store #(.NCLASS(NCLASS), .NENTRY(NENTRY), .DUR_W(DUR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .locked(sched_en[p]),
      .wr(cfg_wr && sel), .len_wr(cfg_len_wr && sel),
      .wr_slot(cfg_slot), .wr_gates(cfg_gates), .wr_ticks(cfg_ticks),
      .wr_len(cfg_len), .rd_slot(rd_slot), .rd_gates(rd_gates),
      .rd_ticks(rd_ticks), .len_q(len_q)
    );

    tas_port_seq #(.NCLASS(NCLASS), .NENTRY(NENTRY), .DUR_W(DUR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(sched_en[p]), .len(len_q),
      .rd_gates(rd_gates), .rd_ticks(rd_ticks), .rd_slot(rd_slot),
      .gates(gate_open[p*NCLASS +: NCLASS]), .evt(gate_evt[p])
    );
  end

  tas_clash_monitor #(.NPORT(NPORT)) u_clash (
    .clk(clk), .rst_n(rst_n), .evt(gate_evt), .clash(clash_err)
  );
endmodule

// File: tb/tas_gate_scheduler_test.sv
`timescale 1ns/1ps
module tas_gate_scheduler_test;
  localparam int NP = 2, NC = 8, NE = 4, DW = 20;
  localparam int IW = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] sched_en = '0;
  logic cfg_wr = 0, cfg_len_wr = 0;
  logic [0:0] cfg_port = '0;
  logic [IW-1:0] cfg_slot = '0;
  logic [NC-1:0] cfg_gates = '0;
  logic [DW-1:0] cfg_ticks = '0;
  logic [CW-1:0] cfg_len = '0;
  logic [NP*NC-1:0] gate_open;
  logic [NP-1:0] gate_evt;
  logic clash_err;

  always #2.5 clk = ~clk;

  tas_gate_scheduler #(.NPORT(NP), .NCLASS(NC), .NENTRY(NE), .DUR_W(DW)) uut (
    .clk, .rst_n, .sched_en, .cfg_wr, .cfg_len_wr, .cfg_port, .cfg_slot,
    .cfg_gates, .cfg_ticks, .cfg_len, .gate_open, .gate_evt, .clash_err);

  int checks = 0, fails = 0;
  int m_mask [NP][NE];
  int m_dur  [NP][NE];
  int m_len  [NP];
  bit act [NP];
  int tt  [NP];
  bit prev_coinc = 0;

  function automatic int eff(int d); return (d == 0) ? 1 : d; endfunction

  function automatic void model(int p, int t, output int m, output bit e);
    int n = (m_len[p] <= 1) ? 1 : ((m_len[p] > NE) ? NE : m_len[p]);
    int total = 0, pos, acc = 0;
    for (int i = 0; i < n; i++) total += eff(m_dur[p][i]);
    pos = t % total;
    m = 0; e = 0;
    for (int i = 0; i < n; i++) begin
      if (pos < acc + eff(m_dur[p][i])) begin
        m = m_mask[p][i]; e = (pos == acc); return;
      end
      acc += eff(m_dur[p][i]);
    end
  endfunction

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // advance one cycle and compare every output against the arithmetic model
  task automatic tick(string req);
    bit e [NP];
    int m;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (act[p]) begin
        tt[p]++;
        model(p, tt[p], m, e[p]);
      end else begin
        m = 8'hFF; e[p] = 0;
      end
      chk(req, gate_open[p*NC +: NC], m);
      chk(req, gate_evt[p], e[p]);
    end
    chk("R8", clash_err, prev_coinc);
    prev_coinc = e[0] && e[1];
  endtask

  task automatic load(int p, int s, int mask, int dur);
    m_mask[p][s] = mask; m_dur[p][s] = dur;
    cfg_port = 1'(p); cfg_slot = IW'(s); cfg_gates = NC'(mask); cfg_ticks = DW'(dur);
    cfg_wr = 1; tick("R1"); cfg_wr = 0;
  endtask

  task automatic set_len(int p, int n);
    m_len[p] = n; cfg_port = 1'(p); cfg_len = CW'(n);
    cfg_len_wr = 1; tick("R5"); cfg_len_wr = 0;
  endtask

  task automatic enable(int p); sched_en[p] = 1; act[p] = 1; tt[p] = -1; endtask
  task automatic disable_p(int p); sched_en[p] = 0; act[p] = 0; endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_len[p] = 1; act[p] = 0; tt[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tick("R1");
    // R2 R3 R4 R5: sweep slot counts and hold-time patterns, zero holds included
    for (int n = 0; n <= 5; n++) begin
      for (int k = 0; k < 3; k++) begin
        int tot = 0;
        for (int s = 0; s < NE; s++)
          load(0, s, (k*37 + s*53 + n*11 + 1) & 8'hFF, (k*3 + s*5 + n) % 7);
        set_len(0, n);
        for (int s = 0; s < NE; s++) tot += eff(m_dur[0][s]);
        enable(0);
        for (int c = 0; c < 3*tot + 3; c++) tick("R4");
        disable_p(0);
        tick("R7");
        tick("R7");
      end
    end
    // R9: two-slot 0x80 / 0x7F schedule, scaled to 100 / 400 ticks
    load(0, 0, 8'h80, 100);
    load(0, 1, 8'h7F, 400);
    set_len(0, 2);
    enable(0);
    for (int c = 0; c < 1100; c++) tick("R9");
    // R6: writes to a running port are ignored
    cfg_port = 0; cfg_slot = 0; cfg_gates = 8'h00; cfg_ticks = 3; cfg_wr = 1;
    cfg_len = 1; cfg_len_wr = 1;
    tick("R6");
    cfg_wr = 0; cfg_len_wr = 0;
    for (int c = 0; c < 1100; c++) tick("R6");
    disable_p(0);
    tick("R7");
    // R7: restart begins at slot 0 again
    enable(0);
    for (int c = 0; c < 120; c++) tick("R7");
    disable_p(0);
    tick("R7");
    // R8: simultaneous start on both ports, then offset collision-free runs
    load(0, 0, 8'h01, 4); load(0, 1, 8'h02, 6); set_len(0, 2);
    load(1, 0, 8'h10, 5); load(1, 1, 8'h20, 5); set_len(1, 2);
    enable(0); enable(1);
    for (int c = 0; c < 80; c++) tick("R8");
    disable_p(0); disable_p(1);
    tick("R8");
    load(1, 0, 8'h10, 10); load(1, 1, 8'h20, 10);
    load(0, 0, 8'h01, 10); load(0, 1, 8'h02, 10);
    enable(0);
    tick("R8"); tick("R8");
    enable(1);
    for (int c = 0; c < 100; c++) tick("R8");
    disable_p(0); disable_p(1);
    tick("R1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule